// File: doc/BRIEF.md
# Counter Clock and Gate Routing Matrix

This block sits in front of a group of counter chips, each holding three counter channels, and decides where every channel takes its count clock and its gate from. Software picks, per channel, a 3-bit clock-source code and a 3-bit gate-source code through a write port. A read port returns the stored codes. The counter channels are outside the block: their outputs come back in as inputs so that one channel can clock or gate another. Channels are numbered globally, with channel g sitting on chip g/3 at position g%3.

Clock sources are the channel's own connector pin, five decade timebases derived from the system clock, the previous channel's output, or a pin shared by the three channels of a chip. Gate sources are a fixed high, a fixed low, the channel's own connector pin, or the inverted output of the channel two places back. The chips form a ring for both cascades. Because a connector pin that is not being used as an input is driven by the board, the block also reports an output-enable flag for every clock pin and every gate pin. The selected clock and gate for each channel are registered once, so they follow their inputs by one clock cycle.

Top module: `cgr_route_matrix`

## Requirements
- R1: After reset every channel reads back clock code 0 and gate code 0, so all clock pin enables are 0 and all gate pin enables are 1.
- R2: A write with `wr_en` high stores `wr_code` into the clock code (`wr_gate`=0) or the gate code (`wr_gate`=1) of channel `wr_ch`; the read port returns exactly the stored 3-bit codes of channel `rd_ch` in the same cycle; a write to a channel index of NUM_CH or above changes no channel.
- R3: With clock code 0, `ch_clk[g]` equals `ext_clk_pin[g]` as sampled at the previous clock edge.
- R4: Clock codes 1, 2, 3, 4 and 5 give a one-cycle pulse on `ch_clk[g]` every PRE_DIV, PRE_DIV*10, PRE_DIV*100, PRE_DIV*1000 and PRE_DIV*10000 cycles respectively, each slower timebase pulsing only in cycles where every faster one pulses.
- R5: With clock code 6, `ch_clk[g]` equals the previous-edge value of `cnt_out[(g-1) mod NUM_CH]`, so channel 0 of a chip takes channel 2 of the preceding chip and the lowest chip follows the highest.
- R6: With clock code 7, `ch_clk[g]` equals the previous-edge value of `chip_ext_clk[g/3]`, shared by all three channels of that chip.
- R7: Gate code 0 drives `ch_gate[g]` to 1 and gate code 1 drives it to 0, one cycle after the code is stored.
- R8: With gate code 2, `ch_gate[g]` equals the previous-edge value of `ext_gate_pin[g]`.
- R9: With gate code 3, `ch_gate[g]` equals the inverse of the previous-edge value of `cnt_out[(g-2) mod NUM_CH]`: channel 0 of its own chip for position 2, and channel position+1 of the preceding chip for positions 0 and 1.
- R10: Gate codes 4 to 7 drive `ch_gate[g]` to 0.
- R11: `clk_pin_oe[g]` is 1 exactly when the stored clock code is not 0, and `gate_pin_oe[g]` is 1 exactly when the stored gate code is not 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the reference for the timebases |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Code write strobe |
| wr_ch | input | CHW | Channel index of the write |
| wr_gate | input | 1 | 0 writes the clock code, 1 writes the gate code |
| wr_code | input | 3 | Code value to store |
| rd_ch | input | CHW | Channel index of the readback |
| rd_clk_code | output | 3 | Stored clock code of channel `rd_ch` (0 when out of range) |
| rd_gate_code | output | 3 | Stored gate code of channel `rd_ch` (0 when out of range) |
| ext_clk_pin | input | NUM_CH | Per-channel clock connector pin, input side |
| ext_gate_pin | input | NUM_CH | Per-channel gate connector pin, input side |
| chip_ext_clk | input | NUM_CHIPS | Per-chip shared external clock pin |
| cnt_out | input | NUM_CH | Counter channel outputs |
| ch_clk | output | NUM_CH | Selected clock of each channel |
| ch_gate | output | NUM_CH | Selected gate of each channel |
| clk_pin_oe | output | NUM_CH | Clock connector pin is driven as an output |
| gate_pin_oe | output | NUM_CH | Gate connector pin is driven as an output |

## Verification
Every cycle the assertions check the pin output-enables against the stored codes, that a write lands in the addressed channel's code, that the fixed and reserved gate codes give the right level, that both ring cascades pick the right neighbour's output one cycle later, and that the timebase pulses nest. Only the bench scenarios show the actual pulse periods of the five timebases, which need windows of up to fifty thousand cycles, along with the readback of out-of-range writes and the reset contents. Random mixes of codes and pin values, plus directed cases at the ring wrap points, compare outputs against a bench model of the routing.

// File: rtl/cgr_pkg.sv
package cgr_pkg;

    localparam int CH_PER_CHIP = 3;
    localparam int CODE_W      = 3;
    localparam int NUM_TB      = 5;

    typedef enum logic [CODE_W-1:0] {
        CLK_PIN     = 3'd0,
        CLK_TB_10M  = 3'd1,
        CLK_TB_1M   = 3'd2,
        CLK_TB_100K = 3'd3,
        CLK_TB_10K  = 3'd4,
        CLK_TB_1K   = 3'd5,
        CLK_PREV    = 3'd6,
        CLK_CHIP    = 3'd7
    } clk_code_e;

    typedef enum logic [CODE_W-1:0] {
        GATE_ON    = 3'd0,
        GATE_OFF   = 3'd1,
        GATE_PIN   = 3'd2,
        GATE_INV2  = 3'd3
    } gate_code_e;

    typedef struct packed {
        logic [CODE_W-1:0] gate;
        logic [CODE_W-1:0] clk;
    } chan_cfg_t;

endpackage

// File: rtl/cgr_timebase.sv
module cgr_timebase
    import cgr_pkg::*;
#(
    parameter int PRE_DIV   = 5,
    parameter int DEC_RATIO = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [NUM_TB-1:0] tb_stb
);

    localparam int PW = $clog2(PRE_DIV + 1);
    localparam int DW = $clog2(DEC_RATIO + 1);

    typedef struct packed {
        logic [PW-1:0]                pre;
        logic [NUM_TB-2:0][DW-1:0]    dec;
    } tb_state_t;

    tb_state_t st_d, st_q;
    logic [NUM_TB-1:0] stb_c;

    always_comb begin
        logic carry;
        st_d  = st_q;
        stb_c = '0;
        carry = (st_q.pre == PW'(PRE_DIV - 1));
        stb_c[0] = carry;
        st_d.pre = carry ? '0 : st_q.pre + 1'b1;
        for (int k = 1; k < NUM_TB; k++) begin
            if (carry) begin
                if (st_q.dec[k-1] == DW'(DEC_RATIO - 1)) begin
                    st_d.dec[k-1] = '0;
                end else begin
                    st_d.dec[k-1] = st_q.dec[k-1] + 1'b1;
                end
            end
            carry    = carry && (st_q.dec[k-1] == DW'(DEC_RATIO - 1));
            stb_c[k] = carry;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tb_stb = stb_c;

endmodule

// File: rtl/cgr_code_bank.sv
module cgr_code_bank
    import cgr_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int CHW    = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [CHW-1:0]           wr_ch,
    input  logic                     wr_gate,
    input  logic [CODE_W-1:0]        wr_code,
    input  logic [CHW-1:0]           rd_ch,
    output chan_cfg_t                rd_cfg,
    output chan_cfg_t [NUM_CH-1:0]   cfg
);

    chan_cfg_t [NUM_CH-1:0] cfg_d, cfg_q;
    logic wr_hit, rd_hit;

    assign wr_hit = wr_en && (int'(wr_ch) < NUM_CH);
    assign rd_hit = (int'(rd_ch) < NUM_CH);

    always_comb begin
        cfg_d = cfg_q;
        for (int g = 0; g < NUM_CH; g++) begin
            if (wr_hit && (int'(wr_ch) == g)) begin
                if (wr_gate) begin
                    cfg_d[g].gate = wr_code;
                end else begin
                    cfg_d[g].clk = wr_code;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        rd_cfg = '0;
        for (int g = 0; g < NUM_CH; g++) begin
            if (rd_hit && (int'(rd_ch) == g)) begin
                rd_cfg = cfg_q[g];
            end
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/cgr_route_mux.sv
module cgr_route_mux
    import cgr_pkg::*;
#(
    parameter int NUM_CHIPS = 2,
    parameter int NUM_CH    = NUM_CHIPS * CH_PER_CHIP
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  chan_cfg_t [NUM_CH-1:0] cfg,
    input  logic [NUM_TB-1:0]      tb_stb,
    input  logic [NUM_CH-1:0]      ext_clk_pin,
    input  logic [NUM_CH-1:0]      ext_gate_pin,
    input  logic [NUM_CHIPS-1:0]   chip_ext_clk,
    input  logic [NUM_CH-1:0]      cnt_out,
    output logic [NUM_CH-1:0]      ch_clk,
    output logic [NUM_CH-1:0]      ch_gate,
    output logic [NUM_CH-1:0]      clk_pin_oe,
    output logic [NUM_CH-1:0]      gate_pin_oe
);

    typedef struct packed {
        logic [NUM_CH-1:0] clk;
        logic [NUM_CH-1:0] gate;
    } route_t;

    route_t rt_d, rt_q;
    logic [NUM_CH-1:0] sel_clk, sel_gate;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        localparam int PREV  = (g + NUM_CH - 1) % NUM_CH;
        localparam int BACK2 = (g + NUM_CH - 2) % NUM_CH;
        localparam int CHIP  = g / CH_PER_CHIP;

        logic c_sel, g_sel;

        always_comb begin
            case (cfg[g].clk)
                CLK_PIN:     c_sel = ext_clk_pin[g];
                CLK_TB_10M:  c_sel = tb_stb[0];
                CLK_TB_1M:   c_sel = tb_stb[1];
                CLK_TB_100K: c_sel = tb_stb[2];
                CLK_TB_10K:  c_sel = tb_stb[3];
                CLK_TB_1K:   c_sel = tb_stb[4];
                CLK_PREV:    c_sel = cnt_out[PREV];
                default:     c_sel = chip_ext_clk[CHIP];
            endcase
        end

        always_comb begin
            case (cfg[g].gate)
                GATE_ON:   g_sel = 1'b1;
                GATE_OFF:  g_sel = 1'b0;
                GATE_PIN:  g_sel = ext_gate_pin[g];
                GATE_INV2: g_sel = ~cnt_out[BACK2];
                default:   g_sel = 1'b0;
            endcase
        end

        assign sel_clk[g]     = c_sel;
        assign sel_gate[g]    = g_sel;
        assign clk_pin_oe[g]  = (cfg[g].clk != 3'(CLK_PIN));
        assign gate_pin_oe[g] = (cfg[g].gate != 3'(GATE_PIN));
    end

    always_comb begin
        rt_d      = rt_q;
        rt_d.clk  = sel_clk;
        rt_d.gate = sel_gate;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rt_q <= '0;
        end else begin
            rt_q <= rt_d;
        end
    end

    assign ch_clk  = rt_q.clk;
    assign ch_gate = rt_q.gate;

endmodule

// File: rtl/cgr_route_matrix.sv
module cgr_route_matrix
    import cgr_pkg::*;
#(
    parameter int NUM_CHIPS = 2,
    parameter int PRE_DIV   = 5,
    parameter int DEC_RATIO = 10,
    localparam int NUM_CH   = NUM_CHIPS * CH_PER_CHIP,
    localparam int CHW      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [CHW-1:0]       wr_ch,
    input  logic                 wr_gate,
    input  logic [2:0]           wr_code,
    input  logic [CHW-1:0]       rd_ch,
    output logic [2:0]           rd_clk_code,
    output logic [2:0]           rd_gate_code,
    input  logic [NUM_CH-1:0]    ext_clk_pin,
    input  logic [NUM_CH-1:0]    ext_gate_pin,
    input  logic [NUM_CHIPS-1:0] chip_ext_clk,
    input  logic [NUM_CH-1:0]    cnt_out,
    output logic [NUM_CH-1:0]    ch_clk,
    output logic [NUM_CH-1:0]    ch_gate,
    output logic [NUM_CH-1:0]    clk_pin_oe,
    output logic [NUM_CH-1:0]    gate_pin_oe
);

    chan_cfg_t [NUM_CH-1:0] cfg;
    chan_cfg_t              rd_cfg;
    logic [NUM_TB-1:0]      tb_stb;
    logic [NUM_CH*3-1:0]    clk_codes, gate_codes;

    cgr_timebase #(
        .PRE_DIV   (PRE_DIV),
        .DEC_RATIO (DEC_RATIO)
    ) u_timebase (
        .clk    (clk),
        .rst_n  (rst_n),
        .tb_stb (tb_stb)
    );

    cgr_code_bank #(
        .NUM_CH (NUM_CH),
        .CHW    (CHW)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_ch   (wr_ch),
        .wr_gate (wr_gate),
        .wr_code (wr_code),
        .rd_ch   (rd_ch),
        .rd_cfg  (rd_cfg),
        .cfg     (cfg)
    );

    cgr_route_mux #(
        .NUM_CHIPS (NUM_CHIPS),
        .NUM_CH    (NUM_CH)
    ) u_mux (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg          (cfg),
        .tb_stb       (tb_stb),
        .ext_clk_pin  (ext_clk_pin),
        .ext_gate_pin (ext_gate_pin),
        .chip_ext_clk (chip_ext_clk),
        .cnt_out      (cnt_out),
        .ch_clk       (ch_clk),
        .ch_gate      (ch_gate),
        .clk_pin_oe   (clk_pin_oe),
        .gate_pin_oe  (gate_pin_oe)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_flat
        assign clk_codes[g*3 +: 3]  = cfg[g].clk;
        assign gate_codes[g*3 +: 3] = cfg[g].gate;
    end

    assign rd_clk_code  = rd_cfg.clk;
    assign rd_gate_code = rd_cfg.gate;

endmodule

// File: rtl/cgr_route_chk.sv
module cgr_route_chk #(
    parameter int NUM_CHIPS = 2,
    parameter int NUM_CH    = NUM_CHIPS * 3,
    parameter int CHW       = 3,
    parameter int NUM_TB    = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [CHW-1:0]      wr_ch,
    input logic                wr_gate,
    input logic [2:0]          wr_code,
    input logic [NUM_CH-1:0]   cnt_out,
    input logic [NUM_CH-1:0]   ch_clk,
    input logic [NUM_CH-1:0]   ch_gate,
    input logic [NUM_CH-1:0]   clk_pin_oe,
    input logic [NUM_CH-1:0]   gate_pin_oe,
    input logic [NUM_CH*3-1:0] clk_codes,
    input logic [NUM_CH*3-1:0] gate_codes,
    input logic [NUM_TB-1:0]   tb_stb
);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        localparam int PREV  = (g + NUM_CH - 1) % NUM_CH;
        localparam int BACK2 = (g + NUM_CH - 2) % NUM_CH;

        // R11
        clk_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
            clk_pin_oe[g] == (clk_codes[g*3 +: 3] != 3'd0));

        // R11
        gate_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
            gate_pin_oe[g] == (gate_codes[g*3 +: 3] != 3'd2));

        // R2
        clk_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (int'(wr_ch) == g) && !wr_gate) |=> (clk_codes[g*3 +: 3] == $past(wr_code)));

        // R2
        gate_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (int'(wr_ch) == g) && wr_gate) |=> (gate_codes[g*3 +: 3] == $past(wr_code)));

        // R7
        gate_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (gate_codes[g*3 +: 3] == 3'd0) |=> ch_gate[g]);

        // R7
        gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (gate_codes[g*3 +: 3] == 3'd1) |=> !ch_gate[g]);

        // R10
        gate_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
            gate_codes[g*3 + 2] |=> !ch_gate[g]);

        // R5
        clk_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clk_codes[g*3 +: 3] == 3'd6) |=> (ch_clk[g] == $past(cnt_out[PREV])));

        // R9
        gate_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (gate_codes[g*3 +: 3] == 3'd3) |=> (ch_gate[g] == !$past(cnt_out[BACK2])));
    end

    for (genvar k = 1; k < NUM_TB; k++) begin : g_tb
        // R4
        tb_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
            tb_stb[k] |-> tb_stb[k-1]);
    end

endmodule

bind cgr_route_matrix cgr_route_chk #(
    .NUM_CHIPS (NUM_CHIPS),
    .NUM_CH    (NUM_CH),
    .CHW       (CHW),
    .NUM_TB    (cgr_pkg::NUM_TB)
) u_route_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_ch       (wr_ch),
    .wr_gate     (wr_gate),
    .wr_code     (wr_code),
    .cnt_out     (cnt_out),
    .ch_clk      (ch_clk),
    .ch_gate     (ch_gate),
    .clk_pin_oe  (clk_pin_oe),
    .gate_pin_oe (gate_pin_oe),
    .clk_codes   (clk_codes),
    .gate_codes  (gate_codes),
    .tb_stb      (tb_stb)
);

// File: tb/tb_cgr_route_matrix.sv
module tb_cgr_route_matrix;

    localparam int NUM_CHIPS = 2;
    localparam int NUM_CH    = 6;
    localparam int CHW       = 3;
    localparam int PRE_DIV   = 5;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 wr_en = 1'b0;
    logic [CHW-1:0]       wr_ch = '0;
    logic                 wr_gate = 1'b0;
    logic [2:0]           wr_code = '0;
    logic [CHW-1:0]       rd_ch = '0;
    logic [2:0]           rd_clk_code, rd_gate_code;
    logic [NUM_CH-1:0]    ext_clk_pin = '0;
    logic [NUM_CH-1:0]    ext_gate_pin = '0;
    logic [NUM_CHIPS-1:0] chip_ext_clk = '0;
    logic [NUM_CH-1:0]    cnt_out = '0;
    logic [NUM_CH-1:0]    ch_clk, ch_gate, clk_pin_oe, gate_pin_oe;

    int n_tests = 0;
    int n_fail  = 0;
    int sh_clk  [NUM_CH];
    int sh_gate [NUM_CH];

    always #10 clk = ~clk;

    cgr_route_matrix #(
        .NUM_CHIPS (NUM_CHIPS),
        .PRE_DIV   (PRE_DIV),
        .DEC_RATIO (10)
    ) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_ch        (wr_ch),
        .wr_gate      (wr_gate),
        .wr_code      (wr_code),
        .rd_ch        (rd_ch),
        .rd_clk_code  (rd_clk_code),
        .rd_gate_code (rd_gate_code),
        .ext_clk_pin  (ext_clk_pin),
        .ext_gate_pin (ext_gate_pin),
        .chip_ext_clk (chip_ext_clk),
        .cnt_out      (cnt_out),
        .ch_clk       (ch_clk),
        .ch_gate      (ch_gate),
        .clk_pin_oe   (clk_pin_oe),
        .gate_pin_oe  (gate_pin_oe)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_clk(input int g, input int code);
        case (code)
            0:       return int'(ext_clk_pin[g]);
            6:       return int'(cnt_out[(g + NUM_CH - 1) % NUM_CH]);
            7:       return int'(chip_ext_clk[g / 3]);
            default: return -1;
        endcase
    endfunction

    function automatic int exp_gate(input int g, input int code);
        case (code)
            0:       return 1;
            1:       return 0;
            2:       return int'(ext_gate_pin[g]);
            3:       return int'(!cnt_out[(g + NUM_CH - 2) % NUM_CH]);
            default: return 0;
        endcase
    endfunction

    task automatic write_code(input int ch, input bit is_gate, input int code);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_ch   = CHW'(ch);
        wr_gate = is_gate;
        wr_code = 3'(code);
        @(negedge clk);
        wr_en = 1'b0;
        if (ch < NUM_CH) begin
            if (is_gate) sh_gate[ch] = code;
            else         sh_clk[ch]  = code;
        end
    endtask

    task automatic check_readback(input string req);
        for (int g = 0; g < NUM_CH; g++) begin
            rd_ch = CHW'(g);
            #1;
            check(req, int'(rd_clk_code), sh_clk[g]);
            check(req, int'(rd_gate_code), sh_gate[g]);
        end
    endtask

    // Sets inputs after a write, lets one edge register them, then checks channel g
    task automatic route_check(input int g);
        @(negedge clk);
        if (exp_clk(g, sh_clk[g]) >= 0) begin
            case (sh_clk[g])
                0:       check("R3", int'(ch_clk[g]), exp_clk(g, 0));
                6:       check("R5", int'(ch_clk[g]), exp_clk(g, 6));
                default: check("R6", int'(ch_clk[g]), exp_clk(g, 7));
            endcase
        end
        case (sh_gate[g])
            0, 1:    check("R7", int'(ch_gate[g]), exp_gate(g, sh_gate[g]));
            2:       check("R8", int'(ch_gate[g]), exp_gate(g, 2));
            3:       check("R9", int'(ch_gate[g]), exp_gate(g, 3));
            default: check("R10", int'(ch_gate[g]), 0);
        endcase
        check("R11 clk oe", int'(clk_pin_oe[g]), int'(sh_clk[g] != 0));
        check("R11 gate oe", int'(gate_pin_oe[g]), int'(sh_gate[g] != 2));
    endtask

    task automatic count_strobes(input int g, input int code, input int window);
        int hits;
        int period;
        hits = 0;
        period = PRE_DIV;
        for (int k = 1; k < code; k++) period = period * 10;
        ext_clk_pin = '0;
        write_code(g, 1'b0, code);
        repeat (2) @(negedge clk);
        for (int c = 0; c < window; c++) begin
            @(negedge clk);
            if (ch_clk[g]) hits++;
        end
        check("R4 timebase pulses", hits, window / period);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h1c0de5));
        for (int g = 0; g < NUM_CH; g++) begin
            sh_clk[g]  = 0;
            sh_gate[g] = 0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: reset contents and enables
        check_readback("R1 reset code");
        check("R1 clk oe after reset", int'(clk_pin_oe), 0);
        check("R1 gate oe after reset", int'(gate_pin_oe), (1 << NUM_CH) - 1);
        check("R7 gate high after reset", int'(ch_gate), (1 << NUM_CH) - 1);

        // R2: writes beyond the last channel change nothing
        write_code(6, 1'b0, 5);
        write_code(7, 1'b1, 3);
        check_readback("R2 out-of-range write");
        rd_ch = CHW'(7);
        #1;
        check("R2 out-of-range read clk", int'(rd_clk_code), 0);
        check("R2 out-of-range read gate", int'(rd_gate_code), 0);

        // Ring corners for R5 and R9
        write_code(0, 1'b0, 6);
        cnt_out = 6'b100000;
        route_check(0);
        write_code(0, 1'b1, 3);
        cnt_out = 6'b010000;
        route_check(0);
        write_code(1, 1'b1, 3);
        cnt_out = 6'b011111;
        route_check(1);
        write_code(2, 1'b1, 3);
        cnt_out = 6'b111110;
        route_check(2);
        write_code(3, 1'b0, 6);
        cnt_out = 6'b000100;
        route_check(3);

        // R6: shared chip clock, chip 1 only
        write_code(4, 1'b0, 7);
        write_code(5, 1'b0, 7);
        write_code(1, 1'b0, 7);
        chip_ext_clk = 2'b10;
        @(negedge clk);
        check("R6 chip1 ch4", int'(ch_clk[4]), 1);
        check("R6 chip1 ch5", int'(ch_clk[5]), 1);
        check("R6 chip0 ch1", int'(ch_clk[1]), 0);

        // R10: every reserved gate code drives low
        for (int c = 4; c < 8; c++) begin
            write_code(5, 1'b1, c);
            route_check(5);
        end

        // Random mix, R2 R3 R5..R11
        for (int it = 0; it < 300; it++) begin
            int g;
            int cc;
            int other;
            g  = int'($urandom_range(0, NUM_CH - 1));
            cc = int'($urandom_range(0, 7));
            write_code(g, 1'b0, cc);
            write_code(g, 1'b1, int'($urandom_range(0, 7)));
            ext_clk_pin  = 6'($urandom);
            ext_gate_pin = 6'($urandom);
            chip_ext_clk = 2'($urandom);
            cnt_out      = 6'($urandom);
            route_check(g);
            rd_ch = CHW'(g);
            #1;
            check("R2 readback clk", int'(rd_clk_code), sh_clk[g]);
            check("R2 readback gate", int'(rd_gate_code), sh_gate[g]);
            other = int'($urandom_range(0, NUM_CH - 1));
            rd_ch = CHW'(other);
            #1;
            check("R2 other channel", int'(rd_clk_code), sh_clk[other]);
        end

        // R4: periods of the five timebases
        count_strobes(3, 1, 1000);
        count_strobes(3, 2, 1000);
        count_strobes(3, 3, 1000);
        count_strobes(3, 4, 10000);
        count_strobes(3, 5, 50000);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule